// File: doc/BRIEF.md
# Clamp-Mode Self-Interleave Arbiter

This block coordinates N parallel inverter legs that feed one shared output capacitor. When the output voltage is pinned to a supply rail, there is almost no voltage across the leg inductors. The slope-based forced turn-off condition then becomes true on every leg in the same cycle. If each leg acted on it alone, the legs would switch in lockstep. The arbiter breaks that symmetry by granting the forced turn-off to one leg per switch polarity. For a high-side turn-off it picks the leg with the largest inductor current. For a low-side turn-off it picks the leg with the smallest. Repeated single-leg commutations then spread the legs apart, so they interleave by themselves. This is stable when the leg count is odd.

Each leg controller raises a request when its own slope condition holds. The arbiter answers with a one-hot grant, which stays asserted until that leg acknowledges that its commutation is complete. On each strobed sample the arbiter also checks a linear bound on how close the output is to each rail. It raises a clamp flag for that rail and, while the flag is set, moves the matching hysteresis turn-off level that it drives to the leg controllers.

Top module: `clamp_interleave_arbiter`

## Requirements
- R1: `hi_grant` is zero or one-hot. A high-side grant goes only to the leg with the largest signed current; on a tie the lowest leg index wins. It is issued only if that leg's `hi_req` bit is set.
- R2: `lo_grant` is zero or one-hot. A low-side grant goes only to the leg with the smallest signed current; on a tie the lowest leg index wins. It is issued only if that leg's `lo_req` bit is set.
- R3: A grant holds its value until the granted leg's acknowledge bit for that polarity is seen at a clock edge. The grant is zero after that edge. An acknowledge on any other leg has no effect.
- R4: Grants are registered. The extremes are taken from the currents present at one edge, and the grant appears only after a later edge that sees the request. A request never changes a grant between edges.
- R5: A request from a leg that is not the extreme leg for that polarity produces no grant.
- R6: Let `M` be the largest leg current. The positive-rail bound holds when 2N·(v_out − v_sup) − ZK·(i_thr − M) ≤ 0. On a `sample_vld` edge, `clamp_pos` sets if the bound holds on this sample and also held on the previous strobed sample, and i_out < i_set. A single sample, or two samples that do not follow each other, never set it.
- R7: Once set, `clamp_pos` stays set while i_out < i_set, even on samples where the bound fails. It clears after the first edge at which i_out ≥ i_set.
- R8: `clamp_neg` mirrors R6 and R7. Let `m` be the smallest leg current. The bound is 2N·(−v_out − v_sup) − ZK·(i_thr + m) ≤ 0, and the flag clears after an edge at which i_out ≤ i_set.
- R9: By default `lo_lvl` is −i_thr when i_set ≥ 0, and 2·i_set − i_thr otherwise. While `clamp_pos` is set, i_out < i_set and i_set < 0, it is (2·i_out)/N − i_thr, with the division truncated toward zero.
- R10: By default `hi_lvl` is 2·i_set + i_thr when i_set ≥ 0, and i_thr otherwise. While `clamp_neg` is set, i_out > i_set and i_set > 0, it is (2·i_out)/N + i_thr, with the division truncated toward zero.
- R11: While `rst` is high, both grants and both clamp flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| leg_cur | input | N*DW | Signed inductor current of each leg; leg k is at bits [k*DW +: DW] |
| hi_req | input | N | Per-leg high-side slope turn-off request |
| lo_req | input | N | Per-leg low-side slope turn-off request |
| hi_ack | input | N | Per-leg high-side commutation acknowledge |
| lo_ack | input | N | Per-leg low-side commutation acknowledge |
| sample_vld | input | 1 | Strobe that marks a new analog sample for the clamp bound |
| v_out | input | DW | Signed output voltage |
| v_sup | input | DW | Supply rail magnitude |
| i_thr | input | DW | Commutation threshold current |
| i_out | input | DW | Signed output current |
| i_set | input | DW | Signed set-point current |
| hi_grant | output | N | One-hot high-side turn-off grant |
| lo_grant | output | N | One-hot low-side turn-off grant |
| clamp_pos | output | 1 | Clamped toward the positive rail |
| clamp_neg | output | 1 | Clamped toward the negative rail |
| hi_lvl | output | DW+2 | Upper turn-off level for all legs |
| lo_lvl | output | DW+2 | Lower turn-off level for all legs |

## Verification
The arbitration is exercised with several current patterns. A distinct maximum and a distinct minimum show that the extremes are found. Equal currents on two or on all legs show the tie-break toward the lowest index. Cases where the extreme leg does not request, while a non-extreme leg does, show that no grant is given. Hold-and-release cases use a wrong-leg acknowledge and a change in which leg is extreme while a grant is outstanding; they separate true holding from re-arbitration. The clamp bound is driven one step on each side of its boundary. It is tried with back-to-back samples, with samples that do not follow each other, and with the exit condition. These cases separate a two-sample qualification from single-sample triggering and show that the flag is sticky. The level outputs are checked in the clamped and default states of both rails, where the division by N truncates.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        RAIL_POS = 1'b0,
        RAIL_NEG = 1'b1
    } rail_e;

    typedef enum logic {
        PICK_MAX = 1'b0,
        PICK_MIN = 1'b1
    } pick_e;

    // True when the left operand should win a comparison node; equality keeps
    // the left (lower-index) side.
    function automatic logic keep_left(input pick_e mode, input longint a, input longint b);
        return (mode == PICK_MAX) ? (a >= b) : (a <= b);
    endfunction

endpackage

// File: rtl/arb_extreme_tree.sv
module arb_extreme_tree
    import arb_pkg::*;
#(
    parameter int    N    = 3,
    parameter int    DW   = 16,
    parameter int    IW   = 2,
    parameter pick_e PICK = PICK_MAX
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N*DW-1:0]      cur,
    output logic                 ext_vld,
    output logic signed [DW-1:0] ext_val,
    output logic [IW-1:0]        ext_idx
);
    localparam int LV    = (N > 1) ? $clog2(N) : 1;
    localparam int P     = 1 << LV;
    localparam int NODES = 2 * P - 1;

    typedef struct packed {
        logic                 ok;
        logic signed [DW-1:0] val;
        logic [IW-1:0]        idx;
    } node_t;

    node_t nd [NODES];

    function automatic node_t merge(input node_t a, input node_t b);
        if (!b.ok) return a;
        if (!a.ok) return b;
        return keep_left(PICK, longint'(a.val), longint'(b.val)) ? a : b;
    endfunction

    genvar k;
    generate
        for (k = 0; k < P; k++) begin : g_leaf
            if (k < N) begin : g_real
                assign nd[P-1+k] = '{ok: 1'b1, val: $signed(cur[k*DW +: DW]), idx: IW'(k)};
            end else begin : g_pad
                assign nd[P-1+k] = '{ok: 1'b0, val: '0, idx: '0};
            end
        end
        for (k = 0; k < P - 1; k++) begin : g_node
            assign nd[k] = merge(nd[2*k+1], nd[2*k+2]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_vld <= 1'b0;
            ext_val <= '0;
            ext_idx <= '0;
        end else begin
            ext_vld <= nd[0].ok;
            ext_val <= nd[0].val;
            ext_idx <= nd[0].idx;
        end
    end

endmodule

// File: rtl/arb_grant_hold.sv
module arb_grant_hold #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_vld,
    input  logic [IW-1:0] sel_idx,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  ack,
    output logic [N-1:0]  grant
);
    logic sel_req;

    always_comb begin
        sel_req = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (sel_idx == IW'(k)) sel_req = req[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant <= '0;
        end else if (|grant) begin
            if (|(grant & ack)) grant <= '0;
        end else if (sel_vld && sel_req) begin
            for (int k = 0; k < N; k++) begin
                grant[k] <= (sel_idx == IW'(k));
            end
        end
    end

endmodule

// File: rtl/arb_clamp_detect.sv
module arb_clamp_detect
    import arb_pkg::*;
#(
    parameter int    N    = 3,
    parameter int    DW   = 16,
    parameter int    ZK   = 4,
    parameter rail_e RAIL = RAIL_POS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_vld,
    input  logic                 ext_vld,
    input  logic signed [DW-1:0] i_ext,
    input  logic signed [DW-1:0] v_out,
    input  logic signed [DW-1:0] v_sup,
    input  logic signed [DW-1:0] i_thr,
    input  logic signed [DW-1:0] i_out,
    input  logic signed [DW-1:0] i_set,
    output logic                 clamp
);
    localparam int BW = 2 * DW + 8;
    localparam logic signed [BW-1:0] TWO_N = BW'(2 * N);
    localparam logic signed [BW-1:0] KZ    = BW'(ZK);

    logic signed [BW-1:0] vo, vs, th, ie, margin;
    logic bound, leave, hit;

    assign vo = {{(BW-DW){v_out[DW-1]}}, v_out};
    assign vs = {{(BW-DW){v_sup[DW-1]}}, v_sup};
    assign th = {{(BW-DW){i_thr[DW-1]}}, i_thr};
    assign ie = {{(BW-DW){i_ext[DW-1]}}, i_ext};

    generate
        if (RAIL == RAIL_POS) begin : g_pos
            assign margin = TWO_N * (vo - vs) - KZ * (th - ie);
            assign leave  = (i_out >= i_set);
        end else begin : g_neg
            assign margin = TWO_N * (-vo - vs) - KZ * (th + ie);
            assign leave  = (i_out <= i_set);
        end
    endgenerate

    assign bound = ext_vld && (margin[BW-1] || (margin == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            clamp <= 1'b0;
            hit   <= 1'b0;
        end else begin
            if (sample_vld) hit <= bound;
            if (leave) clamp <= 1'b0;
            else if (sample_vld && bound && hit) clamp <= 1'b1;
        end
    end

endmodule

// File: rtl/clamp_interleave_arbiter.sv
module clamp_interleave_arbiter
    import arb_pkg::*;
#(
    parameter int N  = 3,
    parameter int DW = 16,
    parameter int ZK = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N*DW-1:0]        leg_cur,
    input  logic [N-1:0]           hi_req,
    input  logic [N-1:0]           lo_req,
    input  logic [N-1:0]           hi_ack,
    input  logic [N-1:0]           lo_ack,
    input  logic                   sample_vld,
    input  logic signed [DW-1:0]   v_out,
    input  logic signed [DW-1:0]   v_sup,
    input  logic signed [DW-1:0]   i_thr,
    input  logic signed [DW-1:0]   i_out,
    input  logic signed [DW-1:0]   i_set,
    output logic [N-1:0]           hi_grant,
    output logic [N-1:0]           lo_grant,
    output logic                   clamp_pos,
    output logic                   clamp_neg,
    output logic signed [DW+1:0]   hi_lvl,
    output logic signed [DW+1:0]   lo_lvl
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int LW = DW + 2;
    localparam logic signed [LW-1:0] NS = LW'(N);

    logic                 max_vld, min_vld;
    logic signed [DW-1:0] max_val, min_val;
    logic [IW-1:0]        max_idx, min_idx;

    arb_extreme_tree #(.N(N), .DW(DW), .IW(IW), .PICK(PICK_MAX)) u_max (
        .clk(clk), .rst(rst), .cur(leg_cur),
        .ext_vld(max_vld), .ext_val(max_val), .ext_idx(max_idx)
    );

    arb_extreme_tree #(.N(N), .DW(DW), .IW(IW), .PICK(PICK_MIN)) u_min (
        .clk(clk), .rst(rst), .cur(leg_cur),
        .ext_vld(min_vld), .ext_val(min_val), .ext_idx(min_idx)
    );

    arb_grant_hold #(.N(N), .IW(IW)) u_hi (
        .clk(clk), .rst(rst), .sel_vld(max_vld), .sel_idx(max_idx),
        .req(hi_req), .ack(hi_ack), .grant(hi_grant)
    );

    arb_grant_hold #(.N(N), .IW(IW)) u_lo (
        .clk(clk), .rst(rst), .sel_vld(min_vld), .sel_idx(min_idx),
        .req(lo_req), .ack(lo_ack), .grant(lo_grant)
    );

    arb_clamp_detect #(.N(N), .DW(DW), .ZK(ZK), .RAIL(RAIL_POS)) u_cpos (
        .clk(clk), .rst(rst), .sample_vld(sample_vld), .ext_vld(max_vld),
        .i_ext(max_val), .v_out(v_out), .v_sup(v_sup), .i_thr(i_thr),
        .i_out(i_out), .i_set(i_set), .clamp(clamp_pos)
    );

    arb_clamp_detect #(.N(N), .DW(DW), .ZK(ZK), .RAIL(RAIL_NEG)) u_cneg (
        .clk(clk), .rst(rst), .sample_vld(sample_vld), .ext_vld(min_vld),
        .i_ext(min_val), .v_out(v_out), .v_sup(v_sup), .i_thr(i_thr),
        .i_out(i_out), .i_set(i_set), .clamp(clamp_neg)
    );

    // Turn-off level computation
    logic signed [LW-1:0] set_x, out_x, thr_x, out_share;

    assign set_x     = {{2{i_set[DW-1]}}, i_set};
    assign out_x     = {{2{i_out[DW-1]}}, i_out};
    assign thr_x     = {{2{i_thr[DW-1]}}, i_thr};
    assign out_share = (out_x + out_x) / NS;

    always_comb begin
        if (clamp_pos && (i_out < i_set) && (i_set < 0))
            lo_lvl = out_share - thr_x;
        else if (i_set >= 0)
            lo_lvl = -thr_x;
        else
            lo_lvl = set_x + set_x - thr_x;

        if (clamp_neg && (i_out > i_set) && (i_set > 0))
            hi_lvl = out_share + thr_x;
        else if (i_set >= 0)
            hi_lvl = set_x + set_x + thr_x;
        else
            hi_lvl = thr_x;
    end

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N  = 3,
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N*DW-1:0]      leg_cur,
    input logic [N-1:0]         hi_req,
    input logic [N-1:0]         lo_req,
    input logic [N-1:0]         hi_ack,
    input logic [N-1:0]         lo_ack,
    input logic                 sample_vld,
    input logic signed [DW-1:0] i_out,
    input logic signed [DW-1:0] i_set,
    input logic [N-1:0]         hi_grant,
    input logic [N-1:0]         lo_grant,
    input logic                 clamp_pos,
    input logic                 clamp_neg
);
    // Granted leg beats every lower index strictly and every higher index or ties.
    function automatic logic pick_ok(input logic [N*DW-1:0] cur, input logic [N-1:0] g,
                                     input logic want_max);
        logic ok;
        logic signed [DW-1:0] cg, ck;
        ok = 1'b1;
        for (int gi = 0; gi < N; gi++) begin
            if (g[gi]) begin
                cg = $signed(cur[gi*DW +: DW]);
                for (int k = 0; k < N; k++) begin
                    ck = $signed(cur[k*DW +: DW]);
                    if (k < gi) ok = ok && (want_max ? (cg > ck) : (cg < ck));
                    if (k > gi) ok = ok && (want_max ? (cg >= ck) : (cg <= ck));
                end
            end
        end
        return ok;
    endfunction

    AST_HI_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(hi_grant)); // R1
    AST_LO_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(lo_grant)); // R2

    AST_HI_PICK: assert property (@(posedge clk) disable iff (rst)
        ($past(hi_grant) == '0 && hi_grant != '0) |->
            (pick_ok($past(leg_cur, 2), hi_grant, 1'b1) && ((($past(hi_req)) & hi_grant) != '0))); // R1
    AST_LO_PICK: assert property (@(posedge clk) disable iff (rst)
        ($past(lo_grant) == '0 && lo_grant != '0) |->
            (pick_ok($past(leg_cur, 2), lo_grant, 1'b0) && ((($past(lo_req)) & lo_grant) != '0))); // R2

    AST_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hi_grant != '0 && (hi_grant & hi_ack) == '0) |=> $stable(hi_grant)); // R3
    AST_HI_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ((hi_grant & hi_ack) != '0) |=> (hi_grant == '0)); // R3
    AST_LO_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ((lo_grant & lo_ack) != '0) |=> (lo_grant == '0)); // R3

    AST_CPOS_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(clamp_pos) |-> $past(sample_vld)); // R6
    AST_CPOS_EXIT: assert property (@(posedge clk) disable iff (rst)
        (i_out >= i_set) |=> !clamp_pos); // R7
    AST_CNEG_EXIT: assert property (@(posedge clk) disable iff (rst)
        (i_out <= i_set) |=> !clamp_neg); // R8

endmodule

bind clamp_interleave_arbiter arb_checker #(.N(N), .DW(DW)) u_chk (.*);

// File: tb/sim_clamp_interleave_arbiter.sv
module sim_clamp_interleave_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 3;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N*DW-1:0] leg_cur = '0;
    logic [N-1:0] hi_req = '0, lo_req = '0, hi_ack = '0, lo_ack = '0;
    logic sample_vld = 1'b0;
    logic signed [DW-1:0] v_out = '0, v_sup = 16'sd100, i_thr = 16'sd10;
    logic signed [DW-1:0] i_out = '0, i_set = '0;
    logic [N-1:0] hi_grant, lo_grant;
    logic clamp_pos, clamp_neg;
    logic signed [DW+1:0] hi_lvl, lo_lvl;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clamp_interleave_arbiter #(.N(N), .DW(DW), .ZK(4)) u0 (
        .clk(clk), .rst(rst), .leg_cur(leg_cur), .hi_req(hi_req), .lo_req(lo_req),
        .hi_ack(hi_ack), .lo_ack(lo_ack), .sample_vld(sample_vld), .v_out(v_out),
        .v_sup(v_sup), .i_thr(i_thr), .i_out(i_out), .i_set(i_set),
        .hi_grant(hi_grant), .lo_grant(lo_grant), .clamp_pos(clamp_pos),
        .clamp_neg(clamp_neg), .hi_lvl(hi_lvl), .lo_lvl(lo_lvl)
    );

    typedef struct packed {
        logic signed [15:0] c0, c1, c2;
        logic [2:0] hr, lr, eh, el;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{16'sd10,   16'sd20,  16'sd5,    3'b111, 3'b111, 3'b010, 3'b100},
        '{16'sd10,   16'sd20,  16'sd5,    3'b101, 3'b011, 3'b000, 3'b000},
        '{16'sd7,    16'sd7,   16'sd3,    3'b111, 3'b111, 3'b001, 3'b100},
        '{-16'sd5,   -16'sd5,  -16'sd5,   3'b111, 3'b111, 3'b001, 3'b001},
        '{-16'sd100, 16'sd50,  16'sd50,   3'b110, 3'b111, 3'b010, 3'b001},
        '{16'sd300,  -16'sd2,  -16'sd300, 3'b001, 3'b100, 3'b001, 3'b100}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cur(input logic signed [15:0] a, b, c);
        leg_cur = {c, b, a};
    endtask

    task automatic sample(input logic signed [15:0] v);
        v_out = v;
        sample_vld = 1'b1;
        tick();
        sample_vld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        // R11: reset state
        check("R11 hi_grant in reset", int'(hi_grant), 0);
        check("R11 lo_grant in reset", int'(lo_grant), 0);
        check("R11 clamp_pos in reset", int'(clamp_pos), 0);
        check("R11 clamp_neg in reset", int'(clamp_neg), 0);
        rst = 1'b0;
        #1;
        check("R9 default lo_lvl set=0", int'(lo_lvl), -10);
        check("R10 default hi_lvl set=0", int'(hi_lvl), 10);
        tick();

        // Table walk: R1, R2, R5 arbitration; R4 registered; R3 release
        for (int i = 0; i < 6; i++) begin
            set_cur(VT[i].c0, VT[i].c1, VT[i].c2);
            tick();
            hi_req = VT[i].hr;
            lo_req = VT[i].lr;
            #1;
            check("R4 no grant before edge", int'(hi_grant | lo_grant), 0);
            tick();
            check("R1 R5 hi_grant vector", int'(hi_grant), int'(VT[i].eh));
            check("R2 R5 lo_grant vector", int'(lo_grant), int'(VT[i].el));
            hi_ack = VT[i].eh;
            lo_ack = VT[i].el;
            hi_req = '0;
            lo_req = '0;
            tick();
            check("R3 released after ack", int'(hi_grant | lo_grant), 0);
            hi_ack = '0;
            lo_ack = '0;
            tick();
        end

        // R3: hold across extreme change and wrong-leg ack
        set_cur(16'sd10, 16'sd20, 16'sd5);
        tick();
        hi_req = 3'b111;
        tick();
        check("R1 hi_grant leg1", int'(hi_grant), 3'b010);
        set_cur(16'sd10, 16'sd20, 16'sd50);
        tick(); tick();
        check("R3 hold while other leg max", int'(hi_grant), 3'b010);
        hi_ack = 3'b001;
        tick();
        check("R3 wrong-leg ack ignored", int'(hi_grant), 3'b010);
        hi_ack = 3'b010;
        tick();
        check("R3 release on own ack", int'(hi_grant), 0);
        hi_ack = '0;
        tick();
        check("R1 regrant to new max", int'(hi_grant), 3'b100);
        hi_req = '0;
        hi_ack = 3'b100;
        tick();
        hi_ack = '0;
        tick();

        // Positive clamp: R6, R7, R9, R10
        set_cur(16'sd20, 16'sd0, -16'sd20);
        i_out = -16'sd40;
        i_set = -16'sd10;
        tick(); tick();
        sample(16'sd94);
        check("R6 bound false at 94", int'(clamp_pos), 0);
        sample(16'sd93);
        check("R6 one sample insufficient", int'(clamp_pos), 0);
        sample(16'sd93);
        check("R6 two samples set clamp_pos", int'(clamp_pos), 1);
        check("R8 clamp_neg held off", int'(clamp_neg), 0);
        check("R9 clamped lo_lvl", int'(lo_lvl), -36);
        check("R10 default hi_lvl set<0", int'(hi_lvl), 10);
        sample(16'sd94);
        check("R7 sticky clamp_pos", int'(clamp_pos), 1);
        i_out = -16'sd10;
        tick();
        check("R7 exit at set-point", int'(clamp_pos), 0);
        check("R9 default lo_lvl set<0", int'(lo_lvl), -30);
        i_out = -16'sd40;
        sample(16'sd93);
        sample(16'sd94);
        sample(16'sd93);
        check("R6 non-consecutive no set", int'(clamp_pos), 0);
        sample(16'sd93);
        check("R6 consecutive set", int'(clamp_pos), 1);
        i_out = -16'sd10;
        tick();

        // Negative clamp: R8, R9, R10
        i_out = 16'sd40;
        i_set = 16'sd10;
        tick();
        sample(-16'sd94);
        check("R8 bound false at -94", int'(clamp_neg), 0);
        sample(-16'sd93);
        sample(-16'sd93);
        check("R8 two samples set clamp_neg", int'(clamp_neg), 1);
        check("R7 clamp_pos held off", int'(clamp_pos), 0);
        check("R10 clamped hi_lvl", int'(hi_lvl), 36);
        check("R9 default lo_lvl set>=0", int'(lo_lvl), -10);
        i_out = 16'sd10;
        tick();
        check("R8 exit at set-point", int'(clamp_neg), 0);
        check("R10 default hi_lvl set>0", int'(hi_lvl), 30);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule